// File: doc/BRIEF.md
# Single-Cycle 32-bit Load/Store Processor Core

This block executes a small register-to-register and load/store instruction subset, retiring exactly one instruction on every rising clock edge. Each cycle the program counter addresses a shared word memory, the fetched word is decoded in two stages (opcode to a two-bit operation class, then class plus function field to a three-bit ALU code), operands are read from a 32 x 32 register file, the ALU computes, and on the edge that ends the cycle the register file, the memory and the program counter all update together.

The supported work is five R-format ALU operations (add, subtract, AND, OR, signed set-less-than), word load, word store and branch-on-equal. One memory array serves both fetch and data access. It is preloaded through a dedicated load port while reset is held. Register 0 is an ordinary writable register. The memory depth is a parameter. The default of 1024 words keeps elaboration small, and setting `ADDR_W` to 15 gives the full 32768-word array.

Top module: `cpu_core`

## Requirements
- R1: A synchronous reset sets the program counter to 0. While reset is high no register or memory write caused by an instruction takes place.
- R2: With opcode 000000, funct 100000 adds and funct 100010 subtracts. Both results wrap modulo 2^32, and the result is written to register rd (bits [15:11]).
- R3: Funct 101010 (ALU code 111) compares rs and rt as signed two's-complement numbers and produces 1 if rs < rt and 0 otherwise, zero-extended to 32 bits.
- R4: `zero_o` is high exactly when all 32 bits of the ALU result are 0, whatever operation is selected.
- R5: Opcode 100011 loads the word at address rs + sign-extended imm[15:0] into register rt. Opcode 101011 stores register rt to that address and writes no register. The memory word index is address bits [ADDR_W+1:2].
- R6: Opcode 000100 subtracts rt from rs. If the result is zero, the next PC is PC+4 + (sign-extended imm << 2). Otherwise, and for every other instruction, the next PC is PC+4.
- R7: ALU codes are derived from the operation class and funct bits F3..F0. The codes are 010 add (loads, stores, funct 100000), 110 subtract (branch, funct 100010), 000 AND (funct 100100) and 001 OR (funct 100101).
- R8: Register 0 is writable and reads back the last value written to it.
- R9: An opcode outside {000000, 100011, 101011, 000100} writes no register and no memory, and the PC advances by 4.
- R10: While `rst` is high, `ld_en` writes `ld_data` into memory word `ld_addr` on the rising edge. The fetched word at the PC is shown on `instr_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| ld_en | input | 1 | Memory preload write enable |
| ld_addr | input | ADDR_W | Preload word index |
| ld_data | input | 32 | Preload word |
| pc_o | output | 32 | Current program counter |
| instr_o | output | 32 | Instruction fetched at the PC |
| alu_res_o | output | 32 | ALU result of the current instruction |
| zero_o | output | 1 | ALU result is all zero |
| mem_we_o | output | 1 | Data store taking place this cycle |
| mem_addr_o | output | 32 | Data byte address (ALU result) |
| mem_wdata_o | output | 32 | Data being stored (register rt) |

## Verification
A decode or ALU-code fault is visible on `alu_res_o` and `zero_o` in the same cycle as the faulty instruction. A wrong next-PC choice shows on `pc_o` one edge later. A register-file fault stays hidden until a later store exposes the register on `mem_wdata_o`, so each test ends with a store of the register under test. Exposure therefore takes between one and three instructions. The operand sweep covers sign boundaries, wrap-around and equal operands for every ALU function. This separates a swapped code bit from a signed/unsigned slip.

// File: rtl/cpu_pkg.sv
package cpu_pkg;

    localparam int XLEN = 32;

    localparam logic [5:0] OPC_RTYPE = 6'b000000;
    localparam logic [5:0] OPC_LOAD  = 6'b100011;
    localparam logic [5:0] OPC_STORE = 6'b101011;
    localparam logic [5:0] OPC_BREQ  = 6'b000100;

    typedef enum logic [2:0] {
        ALU_AND = 3'b000,
        ALU_OR  = 3'b001,
        ALU_ADD = 3'b010,
        ALU_SUB = 3'b110,
        ALU_SLT = 3'b111
    } alu_op_e;

    typedef struct packed {
        logic dst_rd;
        logic opb_imm;
        logic wb_mem;
        logic rf_we;
        logic mem_re;
        logic mem_we;
        logic brnch;
        logic cls_hi;
        logic cls_lo;
    } ctl_t;

endpackage

// File: rtl/cpu_ctrl.sv
module cpu_ctrl
    import cpu_pkg::*;
(
    input  logic [5:0] opcode,
    input  logic [3:0] fn_lo,
    output ctl_t       ctl,
    output alu_op_e    alu_op
);

    logic is_r, is_ld, is_st, is_bq;
    logic [2:0] code;

    always_comb begin
        is_r  = (opcode == OPC_RTYPE);
        is_ld = (opcode == OPC_LOAD);
        is_st = (opcode == OPC_STORE);
        is_bq = (opcode == OPC_BREQ);

        ctl.dst_rd  = is_r;
        ctl.cls_hi  = is_r;
        ctl.wb_mem  = is_ld;
        ctl.mem_re  = is_ld;
        ctl.mem_we  = is_st;
        ctl.brnch   = is_bq;
        ctl.cls_lo  = is_bq;
        ctl.opb_imm = is_ld | is_st;
        ctl.rf_we   = is_r | is_ld;
    end

    // second-level decode: class bits plus low funct bits
    always_comb begin
        code[2] = ctl.cls_lo | (ctl.cls_hi & fn_lo[1]);
        code[1] = ~ctl.cls_hi | ~fn_lo[2];
        code[0] = ctl.cls_hi & (fn_lo[0] | fn_lo[3]);
        alu_op  = alu_op_e'(code);
    end

    always_comb begin
        if (ctl.mem_we) AST_STORE_NO_WB: assert (!ctl.rf_we);          // R5
        if (ctl.brnch)  AST_BRANCH_SUBTRACTS: assert (alu_op == ALU_SUB); // R6
        if (ctl.opb_imm) AST_MEMOP_ADDS: assert (alu_op == ALU_ADD);    // R7
    end

endmodule

// File: rtl/cpu_alu.sv
module cpu_alu
    import cpu_pkg::*;
#(
    parameter int DW = XLEN
) (
    input  logic [DW-1:0] opa,
    input  logic [DW-1:0] opb,
    input  alu_op_e       op,
    output logic [DW-1:0] res,
    output logic          zero
);

    always_comb begin
        unique case (op)
            ALU_ADD: res = opa + opb;
            ALU_SUB: res = opa - opb;
            ALU_AND: res = opa & opb;
            ALU_OR:  res = opa | opb;
            ALU_SLT: res = {{(DW-1){1'b0}}, ($signed(opa) < $signed(opb))};
            default: res = '0;
        endcase
        zero = ~|res;
    end

    always_comb begin
        if (op == ALU_SLT) AST_SLT_IS_BOOLEAN: assert (res[DW-1:1] == '0); // R3
        if (op == ALU_SUB && zero) AST_ZERO_MEANS_EQUAL: assert (opa == opb); // R4
    end

endmodule

// File: rtl/cpu_regfile.sv
module cpu_regfile #(
    parameter int DW   = 32,
    parameter int RA_W = 5
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            we,
    input  logic [RA_W-1:0] wa,
    input  logic [DW-1:0]   wd,
    input  logic [RA_W-1:0] ra1,
    input  logic [RA_W-1:0] ra2,
    output logic [DW-1:0]   rd1,
    output logic [DW-1:0]   rd2
);

    localparam int NREG = 1 << RA_W;

    logic [DW-1:0] regs [NREG];

    // no entry is hard-wired: index 0 stores like any other
    always_ff @(posedge clk) begin
        if (we) regs[wa] <= wd;
    end

    assign rd1 = regs[ra1];
    assign rd2 = regs[ra2];

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
        we |=> (regs[$past(wa)] == $past(wd)));                   // R8

endmodule

// File: rtl/cpu_mem.sv
module cpu_mem #(
    parameter int DW = 32,
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] iaddr,
    output logic [DW-1:0] idata,
    input  logic [AW-1:0] daddr,
    input  logic          re,
    output logic [DW-1:0] rdata
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] arr [DEPTH];

    always_ff @(posedge clk) begin
        if (we) arr[waddr] <= wdata;
    end

    assign idata = arr[iaddr];
    assign rdata = re ? arr[daddr] : '0;

endmodule

// File: rtl/cpu_core.sv
module cpu_core
    import cpu_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_en,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [31:0]       ld_data,
    output logic [31:0]       pc_o,
    output logic [31:0]       instr_o,
    output logic [31:0]       alu_res_o,
    output logic              zero_o,
    output logic              mem_we_o,
    output logic [31:0]       mem_addr_o,
    output logic [31:0]       mem_wdata_o
);

    localparam int RA_W = 5;

    logic [31:0] pc_q, pc_next, pc_plus4, br_tgt, imm_ext;
    logic [31:0] instr, opa, rs2_val, opb, alu_res, mem_rd, wb_val;
    logic [RA_W-1:0] f_rs, f_rt, f_rd, wr_idx;
    logic        zero, take_br, rf_we, st_we, mem_we;
    logic [ADDR_W-1:0] m_waddr;
    logic [31:0]       m_wdata;
    ctl_t        ctl;
    alu_op_e     alu_op;

    // ---------------- program counter ----------------
    always_ff @(posedge clk) begin
        if (rst) pc_q <= '0;
        else     pc_q <= pc_next;
    end

    always_comb begin
        pc_plus4 = pc_q + 32'd4;
        imm_ext  = {{16{instr[15]}}, instr[15:0]};
        br_tgt   = pc_plus4 + {imm_ext[29:0], 2'b00};
        take_br  = ctl.brnch & zero;
        pc_next  = take_br ? br_tgt : pc_plus4;
    end

    // ---------------- field extraction ----------------
    assign f_rs = instr[25:21];
    assign f_rt = instr[20:16];
    assign f_rd = instr[15:11];

    cpu_ctrl u_ctrl (
        .opcode (instr[31:26]),
        .fn_lo  (instr[3:0]),
        .ctl    (ctl),
        .alu_op (alu_op)
    );

    // ---------------- register file ----------------
    assign wr_idx = ctl.dst_rd ? f_rd : f_rt;
    assign wb_val = ctl.wb_mem ? mem_rd : alu_res;
    assign rf_we  = ctl.rf_we & ~rst;

    cpu_regfile #(.DW(32), .RA_W(RA_W)) u_rf (
        .clk (clk),
        .rst (rst),
        .we  (rf_we),
        .wa  (wr_idx),
        .wd  (wb_val),
        .ra1 (f_rs),
        .ra2 (f_rt),
        .rd1 (opa),
        .rd2 (rs2_val)
    );

    // ---------------- execute ----------------
    assign opb = ctl.opb_imm ? imm_ext : rs2_val;

    cpu_alu #(.DW(32)) u_alu (
        .opa  (opa),
        .opb  (opb),
        .op   (alu_op),
        .res  (alu_res),
        .zero (zero)
    );

    // ---------------- shared memory ----------------
    assign st_we   = ctl.mem_we & ~rst;
    assign mem_we  = ld_en | st_we;
    assign m_waddr = ld_en ? ld_addr : alu_res[ADDR_W+1:2];
    assign m_wdata = ld_en ? ld_data : rs2_val;

    cpu_mem #(.DW(32), .AW(ADDR_W)) u_mem (
        .clk   (clk),
        .we    (mem_we),
        .waddr (m_waddr),
        .wdata (m_wdata),
        .iaddr (pc_q[ADDR_W+1:2]),
        .idata (instr),
        .daddr (alu_res[ADDR_W+1:2]),
        .re    (ctl.mem_re),
        .rdata (mem_rd)
    );

    assign pc_o        = pc_q;
    assign instr_o     = instr;
    assign alu_res_o   = alu_res;
    assign zero_o      = zero;
    assign mem_we_o    = st_we;
    assign mem_addr_o  = alu_res;
    assign mem_wdata_o = rs2_val;

    AST_PC_CLEARED: assert property (@(posedge clk)
        rst |=> (pc_q == '0));                                     // R1
    AST_PC_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        pc_q[1:0] == 2'b00);                                       // R6
    AST_PC_PLUS_FOUR: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(ctl.brnch)) |-> (pc_q == $past(pc_q) + 32'd4)); // R6
    AST_NO_WRITE_IN_RESET: assert property (@(posedge clk)
        rst |-> (!mem_we_o && !rf_we));                            // R1

endmodule

// File: tb/cpu_core_tb.sv
`timescale 1ns/100ps
module cpu_core_tb;

    localparam int AW = 10;
    localparam logic [5:0] F_ADD = 6'b100000, F_SUB = 6'b100010,
                           F_AND = 6'b100100, F_OR  = 6'b100101,
                           F_SLT = 6'b101010;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ld_en = 1'b0;
    logic [AW-1:0] ld_addr = '0;
    logic [31:0]   ld_data = '0;
    logic [31:0]   pc_o, instr_o, alu_res_o, mem_addr_o, mem_wdata_o;
    logic          zero_o, mem_we_o;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    cpu_core #(.ADDR_W(AW)) u_dut (
        .clk(clk), .rst(rst), .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data),
        .pc_o(pc_o), .instr_o(instr_o), .alu_res_o(alu_res_o), .zero_o(zero_o),
        .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o)
    );

    function automatic logic [31:0] rop(input logic [4:0] rs, rt, rd, input logic [5:0] fn);
        return {6'b000000, rs, rt, rd, 5'd0, fn};
    endfunction
    function automatic logic [31:0] iop(input logic [5:0] op, input logic [4:0] rs, rt,
                                        input logic [15:0] imm);
        return {op, rs, rt, imm};
    endfunction
    function automatic logic [31:0] expect_alu(input logic [5:0] fn, input logic [31:0] a, b);
        case (fn)
            F_ADD:   return a + b;
            F_SUB:   return a - b;
            F_AND:   return a & b;
            F_OR:    return a | b;
            default: return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic load(input int idx, input logic [31:0] w);
        rst = 1'b1; ld_en = 1'b1; ld_addr = AW'(idx); ld_data = w;
        step();
        ld_en = 1'b0;
    endtask

    task automatic go();
        ld_en = 1'b0; rst = 1'b0;
        #1;
    endtask

    task automatic base_prog(input logic [31:0] a, b);
        load(0, rop(5'd0, 5'd0, 5'd0, F_SUB));          // clear r0
        load(1, iop(6'b100011, 5'd0, 5'd1, 16'd400));   // r1 <- word 100
        load(2, iop(6'b100011, 5'd0, 5'd2, 16'd404));   // r2 <- word 101
        load(100, a);
        load(101, b);
    endtask

    initial begin
        #1000000;
        bad++; total++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] ops [8];
        logic [5:0]  fns [5];
        ops[0] = 32'h0;        ops[1] = 32'h1;        ops[2] = 32'hFFFF_FFFF;
        ops[3] = 32'h7FFF_FFFF; ops[4] = 32'h8000_0000; ops[5] = 32'h5;
        ops[6] = 32'hFFFF_FFFB; ops[7] = 32'h1234_5678;
        fns[0] = F_ADD; fns[1] = F_SUB; fns[2] = F_AND; fns[3] = F_OR; fns[4] = F_SLT;

        // R1: reset state
        step(); step();
        chk(pc_o == 32'd0, "R1 pc in reset", pc_o, 32'd0);
        chk(mem_we_o == 1'b0, "R1 no store in reset", {31'd0, mem_we_o}, 32'd0);

        // sweep every function over every operand pair: R2 R3 R4 R5 R7
        for (int f = 0; f < 5; f++) begin
            for (int i = 0; i < 8; i++) begin
                for (int j = 0; j < 8; j++) begin
                    logic [31:0] e;
                    string tag;
                    e = expect_alu(fns[f], ops[i], ops[j]);
                    tag = (fns[f] == F_SLT) ? "R3 slt" :
                          (fns[f] == F_ADD || fns[f] == F_SUB) ? "R2 add/sub" : "R7 and/or";
                    base_prog(ops[i], ops[j]);
                    load(3, rop(5'd1, 5'd2, 5'd3, fns[f]));
                    load(4, iop(6'b101011, 5'd0, 5'd3, 16'd408));
                    go();
                    if (f == 0 && i == 0 && j == 0)
                        chk(instr_o == rop(5'd0, 5'd0, 5'd0, F_SUB), "R10 preload fetch",
                            instr_o, rop(5'd0, 5'd0, 5'd0, F_SUB));
                    step(); step(); step();
                    chk(alu_res_o == e, tag, alu_res_o, e);
                    chk(zero_o == (e == 32'd0), "R4 zero flag", {31'd0, zero_o},
                        {31'd0, (e == 32'd0)});
                    step();
                    chk(mem_we_o && mem_addr_o == 32'd408 && mem_wdata_o == e,
                        "R5 store of rd result", mem_wdata_o, e);
                end
            end
        end

        // R1: reset in mid-run clears the PC
        rst = 1'b1; step();
        chk(pc_o == 32'd0, "R1 pc after mid-run reset", pc_o, 32'd0);

        // R6: branch taken forward, not taken, taken backward
        base_prog(32'h33, 32'h33);
        load(3, iop(6'b000100, 5'd1, 5'd2, 16'd3));
        go(); step(); step(); step(); step();
        chk(pc_o == 32'd28, "R6 branch taken", pc_o, 32'd28);

        base_prog(32'h33, 32'h34);
        load(3, iop(6'b000100, 5'd1, 5'd2, 16'd3));
        go(); step(); step(); step(); step();
        chk(pc_o == 32'd16, "R6 branch not taken", pc_o, 32'd16);

        base_prog(32'h7, 32'h7);
        load(3, iop(6'b000100, 5'd1, 5'd2, 16'hFFFC));
        go(); step(); step(); step(); step();
        chk(pc_o == 32'd0, "R6 backward branch", pc_o, 32'd0);

        // R5: load into rt, then store it back
        base_prog(32'hCAFE_0001, 32'h0);
        load(3, iop(6'b101011, 5'd0, 5'd1, 16'd412));
        go(); step(); step(); step();
        chk(mem_we_o && mem_addr_o == 32'd412 && mem_wdata_o == 32'hCAFE_0001,
            "R5 load then store", mem_wdata_o, 32'hCAFE_0001);

        // R8: register 0 holds a written value
        load(0, rop(5'd0, 5'd0, 5'd0, F_SUB));
        load(1, iop(6'b100011, 5'd0, 5'd0, 16'd400));
        load(2, iop(6'b101011, 5'd0, 5'd0, 16'd8));
        load(100, 32'h100);
        go(); step(); step();
        chk(mem_addr_o == 32'h108, "R8 r0 as base", mem_addr_o, 32'h108);
        chk(mem_wdata_o == 32'h100, "R8 r0 as data", mem_wdata_o, 32'h100);

        // R9: unlisted opcode (001000) changes neither r1 nor memory
        base_prog(32'h55, 32'h0);
        load(2, iop(6'b001000, 5'd0, 5'd1, 16'd1));
        load(3, iop(6'b101011, 5'd0, 5'd1, 16'd408));
        go(); step(); step();
        chk(mem_we_o == 1'b0, "R9 no store", {31'd0, mem_we_o}, 32'd0);
        step();
        chk(pc_o == 32'd12, "R9 pc advances", pc_o, 32'd12);
        chk(mem_wdata_o == 32'h55, "R9 r1 unchanged", mem_wdata_o, 32'h55);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule